// File: doc/BRIEF.md
# Two-Level Paged Address Translator

This block turns 32-bit virtual addresses from a processor request port into physical addresses. The address is split into a 10-bit outer index, a 10-bit inner index and a 12-bit page offset, so pages are 4 KB. A 32-entry fully associative translation cache is searched first. On a hit the physical address is returned in the next cycle and memory is not read.

On a miss, a walker reads the outer table entry and then the inner table entry through a single-outstanding valid/ready memory read port. A successful result is installed in the cache. An outer index at or beyond the table length input faults at once. An entry whose valid bit is clear ends the walk with a fault code that names the level.

Software-visible context comes in as two plain inputs: the outer table base and the outer table length. A flush input empties the cache in one cycle.

Top module: `xl_translator`

## Requirements
- R1: A table entry holds a valid flag in bit 0 and a 20-bit base in bits 31:12. The physical address of a good translation is the inner entry's base in bits 31:12, joined to the request's bits 11:0 unchanged.
- R2: A miss reads the outer entry at {table_base[31:12], va[31:22], 2'b00} first. It then reads the inner entry at {outer_entry[31:12], va[21:12], 2'b00}. A successful miss performs exactly these two reads.
- R3: When {1'b0, va[31:22]} >= table_len, the response carries code 1 one cycle after acceptance, and no memory read is made. This holds even for a page that is held in the cache.
- R4: An outer entry with bit 0 clear gives code 2 after one read. An inner entry with bit 0 clear gives code 3 after two reads. A good translation carries code 0. Every faulting response carries a physical address of zero.
- R5: A cache hit answers with code 0 in the cycle after acceptance and makes no memory read.
- R6: A walk that faults installs nothing, so repeating the same request walks memory again.
- R7: A good walk installs its page. The cache holds 32 pages and never matches one page in two entries. Empty entries are filled lowest index first. When the cache is full, the victim is chosen by a round-robin pointer that starts at entry 0 and advances on each replacement.
- R8: Flush empties the cache in one cycle. A request accepted while flush is high is treated as a miss. An install that falls in a flush cycle is dropped.
- R9: req_ready is low from acceptance of a miss until its response. Only one memory read is outstanding at a time. A pending read holds its valid and its address until it is accepted.
- R10: After reset, req_ready is 1, rsp_valid is 0, mem_req_valid is 0 and the cache is empty.
- R11: Each accepted request yields exactly one response, valid for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the translation cache |
| tbl_base | input | 32 | Outer table location; bits 31:12 are used |
| tbl_len | input | 11 | Number of legal outer indices (0 to 1024) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_code | output | 2 | 0 ok, 1 length, 2 outer invalid, 3 inner invalid |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | 32 | Table entry byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
Flush can meet two other functions in the same cycle: a fresh lookup, and the install at the end of a walk. The bench raises flush together with a request for a cached page, and it must see that request walk memory. It also makes its memory model assert flush in exactly the cycle that it returns an inner entry. That walk must still return the right address, and the next access to the same page must walk again, which shows the install was dropped.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = VPN_W;
  localparam int LEN_W = IDX_W + 1;
  localparam int PTE_W = 32;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LEN   = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    W_IDLE, W_OREQ, W_OWAIT, W_IREQ, W_IWAIT
  } wstate_e;

  function automatic logic [IDX_W-1:0] outer_idx(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] inner_idx(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  // entry byte address: table page base, index, word alignment
  function automatic logic [VA_W-1:0] pte_addr(input logic [VPN_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return {base, idx, 2'b00};
  endfunction

  function automatic logic pte_valid(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [PFN_W-1:0] pte_base(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1:OFF_W];
  endfunction

  function automatic logic [VA_W-1:0] make_pa(input logic [PFN_W-1:0] pfn,
                                               input logic [VA_W-1:0] va);
    return {pfn, va[OFF_W-1:0]};
  endfunction

  function automatic logic len_ok(input logic [IDX_W-1:0] idx,
                                  input logic [LEN_W-1:0] len);
    return {1'b0, idx} < len;
  endfunction
endpackage

// File: rtl/xl_tcache.sv
module xl_tcache
  import xl_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic [ENTRIES-1:0] match_vec,
  input  logic               ins_en,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PFN_W-1:0]   ins_pfn
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PFN_W-1:0]   pfn [ENTRIES];
  logic [IW-1:0]      rr_ptr;
  logic [IW-1:0]      free_idx;
  logic               have_free;
  logic [IW-1:0]      victim;
  logic               do_write;

  // parallel compare across every entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = vld[g] && (tag[g] == lk_vpn);
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) lk_pfn = lk_pfn | pfn[i];
    end
  end
  assign lk_hit = |match_vec;

  // lowest empty slot wins
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        have_free = 1'b1;
        free_idx  = IW'(i);
      end
    end
  end

  assign victim   = have_free ? free_idx : rr_ptr;
  assign do_write = ins_en && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (ins_en) begin
      vld[victim] <= 1'b1;
      if (!have_free) rr_ptr <= rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      tag[victim] <= ins_vpn;
      pfn[victim] <= ins_pfn;
    end
  end
endmodule

// File: rtl/xl_walker.sv
module xl_walker
  import xl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  start_va,
  input  logic [VPN_W-1:0] tbl_page,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output fault_e           done_code,
  output logic [VPN_W-1:0] done_vpn,
  output logic [PFN_W-1:0] done_pfn,
  output logic [VA_W-1:0]  done_paddr
);
  wstate_e          st;
  logic [VA_W-1:0]  va_q;
  logic [VPN_W-1:0] obase_q;
  logic [VPN_W-1:0] ibase_q;
  logic             unused_rsp_mid;

  assign unused_rsp_mid = ^mem_rsp_data[OFF_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      va_q    <= '0;
      obase_q <= '0;
      ibase_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          st      <= W_OREQ;
          va_q    <= start_va;
          obase_q <= tbl_page;
        end
        W_OREQ:  if (mem_req_ready) st <= W_OWAIT;
        W_OWAIT: if (mem_rsp_valid) begin
          if (pte_valid(mem_rsp_data)) begin
            ibase_q <= pte_base(mem_rsp_data);
            st      <= W_IREQ;
          end else begin
            st <= W_IDLE;
          end
        end
        W_IREQ:  if (mem_req_ready) st <= W_IWAIT;
        W_IWAIT: if (mem_rsp_valid) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy          = (st != W_IDLE);
  assign mem_req_valid = (st == W_OREQ) || (st == W_IREQ);
  assign mem_req_addr  = (st == W_IREQ) ? pte_addr(ibase_q, inner_idx(va_q))
                                        : pte_addr(obase_q, outer_idx(va_q));
  assign done_vpn      = vpn_of(va_q);

  always_comb begin
    done      = 1'b0;
    done_code = FLT_NONE;
    done_pfn  = '0;
    if (st == W_OWAIT && mem_rsp_valid && !pte_valid(mem_rsp_data)) begin
      done      = 1'b1;
      done_code = FLT_OUTER;
    end
    if (st == W_IWAIT && mem_rsp_valid) begin
      done      = 1'b1;
      done_code = pte_valid(mem_rsp_data) ? FLT_NONE : FLT_INNER;
      done_pfn  = pte_base(mem_rsp_data);
    end
    done_paddr = (done_code == FLT_NONE) ? make_pa(done_pfn, va_q) : '0;
  end
endmodule

// File: rtl/xl_translator.sv
module xl_translator
  import xl_pkg::*;
#(
  parameter int TLB_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [31:0] tbl_base,
  input  logic [10:0] tbl_len,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_code,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  logic                   accept;
  logic                   len_bad;
  logic                   lk_hit;
  logic [PFN_W-1:0]       lk_pfn;
  logic [TLB_ENTRIES-1:0] cache_match;
  logic                   ev_hit, ev_miss, ev_lenfault, ev_install;
  logic                   wk_busy, wk_done;
  fault_e                 wk_code;
  logic [VPN_W-1:0]       wk_vpn;
  logic [PFN_W-1:0]       wk_pfn;
  logic [VA_W-1:0]        wk_paddr;
  fault_e                 code_q;
  logic                   unused_base_lo;

  assign unused_base_lo = ^tbl_base[OFF_W-1:0];

  assign req_ready   = !wk_busy;
  assign accept      = req_valid && req_ready;
  assign len_bad     = !len_ok(outer_idx(req_vaddr), tbl_len);
  assign ev_lenfault = accept && len_bad;
  assign ev_hit      = accept && !len_bad && lk_hit && !flush;
  assign ev_miss     = accept && !len_bad && !(lk_hit && !flush);
  assign ev_install  = wk_done && (wk_code == FLT_NONE);

  xl_tcache #(.ENTRIES(TLB_ENTRIES)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (vpn_of(req_vaddr)),
    .lk_hit   (lk_hit),
    .lk_pfn   (lk_pfn),
    .match_vec(cache_match),
    .ins_en   (ev_install),
    .ins_vpn  (wk_vpn),
    .ins_pfn  (wk_pfn)
  );

  xl_walker u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (ev_miss),
    .start_va     (req_vaddr),
    .tbl_page     (tbl_base[VA_W-1:OFF_W]),
    .busy         (wk_busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .done         (wk_done),
    .done_code    (wk_code),
    .done_vpn     (wk_vpn),
    .done_pfn     (wk_pfn),
    .done_paddr   (wk_paddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      code_q    <= FLT_NONE;
    end else begin
      rsp_valid <= 1'b0;
      if (ev_lenfault) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= '0;
        code_q    <= FLT_LEN;
      end else if (ev_hit) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= make_pa(lk_pfn, req_vaddr);
        code_q    <= FLT_NONE;
      end else if (wk_done) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= wk_paddr;
        code_q    <= wk_code;
      end
    end
  end

  assign rsp_code = code_q;
endmodule

// File: rtl/xl_translator_chk.sv
module xl_translator_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [10:0]        tbl_len,
  input logic               req_valid,
  input logic               req_ready,
  input logic [31:0]        req_vaddr,
  input logic               rsp_valid,
  input logic [31:0]        rsp_paddr,
  input logic [1:0]         rsp_code,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [31:0]        mem_req_addr,
  input logic               ev_hit,
  input logic               ev_miss,
  input logic [ENTRIES-1:0] cache_match
);
  AST_LEN_FAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_vaddr[31:22]} >= tbl_len) |=> rsp_valid && rsp_code == 2'd1); // R3
  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> rsp_valid && rsp_code == 2'd0 && !mem_req_valid); // R5
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cache_match)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_NO_ACCEPT_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R9
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != 2'd0 |-> rsp_paddr == 32'd0); // R4
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush && req_valid && req_ready && ({1'b0, req_vaddr[31:22]} < tbl_len) |=> !rsp_valid); // R8
  AST_MISS_READS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> mem_req_valid); // R2
endmodule

bind xl_translator xl_translator_chk #(.ENTRIES(TLB_ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .tbl_len      (tbl_len),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_code     (rsp_code),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .ev_hit       (ev_hit),
  .ev_miss      (ev_miss),
  .cache_match  (cache_match)
);

// File: tb/xl_translator_tb_top.sv
module xl_translator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL_BASE = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_flush = 1'b0;
  logic        mem_flush = 1'b0;
  logic        flush;
  logic [10:0] tbl_len = 11'd16;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_code;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int mem_stall = 0;
  int stall_left = 0;
  bit pend = 0;
  bit flush_at_inner = 0;
  logic [31:0] pend_addr;
  logic [31:0] rd_log [4];

  assign flush = tb_flush | mem_flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  xl_translator dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .tbl_base(TBL_BASE), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_code(rsp_code),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // table contents are formulas of the indices
  function automatic logic [19:0] frame_of(int i, int j);
    return 20'(i * 37 + j * 5 + 3);
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    int i, j;
    if (a[31:12] == TBL_BASE[31:12]) begin
      i = int'(a[11:2]);
      return {20'(32'h100 + i), 11'd0, (i % 7 != 5)};
    end
    i = int'(a[31:12]) - 32'h100;
    j = int'(a[11:2]);
    return {frame_of(i, j), 11'd0, (j % 11 != 3)};
  endfunction

  function automatic logic [33:0] expect_xl(logic [31:0] va, logic [10:0] len);
    int i = int'(va[31:22]);
    int j = int'(va[21:12]);
    if (i >= int'(len)) return {2'd1, 32'd0};
    if (i % 7 == 5)     return {2'd2, 32'd0};
    if (j % 11 == 3)    return {2'd3, 32'd0};
    return {2'd0, frame_of(i, j), va[11:0]};
  endfunction

  function automatic logic [31:0] mkva(int i, int j, int off);
    return {10'(i), 10'(j), 12'(off)};
  endfunction

  // memory model, driven on the falling edge
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_flush = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = mem_word(pend_addr);
      if (flush_at_inner && pend_addr[31:12] != TBL_BASE[31:12]) mem_flush = 1'b1;
      pend = 0;
    end
    if (mem_req_ready) begin
      mem_req_ready = 1'b0;
    end else if (mem_req_valid) begin
      if (stall_left > 0) stall_left--;
      else begin
        mem_req_ready = 1'b1;
        pend = 1;
        pend_addr = mem_req_addr;
        rd_log[reads % 4] = mem_req_addr;
        reads++;
        stall_left = mem_stall;
      end
    end else begin
      stall_left = mem_stall;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one request; called and returns at a falling edge
  task automatic do_req(input logic [31:0] va, input bit with_flush,
                        output logic [1:0] code, output logic [31:0] pa,
                        output int nrd, output int lat, output int rdy_busy, output bit pulse_ok);
    int r0 = reads;
    req_valid = 1'b1;
    req_vaddr = va;
    tb_flush = with_flush;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    tb_flush = 1'b0;
    lat = 1;
    rdy_busy = 0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) rdy_busy++;
      @(negedge clk);
      lat++;
    end
    code = rsp_code;
    pa = rsp_paddr;
    nrd = reads - r0;
    @(negedge clk);
    pulse_ok = !rsp_valid;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] code;
    logic [31:0] pa, va;
    logic [33:0] ex;
    int nrd, lat, rb, r0;
    bit pk;
    int pg [33];
    int n;

    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R10 rsp", 32'(rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R10 memreq", 32'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // first miss: two reads in order, correct address
    va = mkva(2, 7, 12'h123);
    r0 = reads;
    do_req(va, 0, code, pa, nrd, lat, rb, pk);
    ex = expect_xl(va, tbl_len);
    chk(code == 2'd0 && pa == ex[31:0], "R1 miss pa", pa, ex[31:0]);
    chk(nrd == 2, "R2 miss reads", 32'(nrd), 2);
    chk(rd_log[r0 % 4] == {TBL_BASE[31:12], 10'd2, 2'b00}, "R2 outer addr", rd_log[r0 % 4], {TBL_BASE[31:12], 10'd2, 2'b00});
    chk(rd_log[(r0 + 1) % 4] == {20'h102, 10'd7, 2'b00}, "R2 inner addr", rd_log[(r0 + 1) % 4], {20'h102, 10'd7, 2'b00});
    chk(lat == 5, "R9 miss latency", 32'(lat), 5);
    chk(rb == 0, "R9 ready low in walk", 32'(rb), 0);
    chk(pk, "R11 single pulse", 32'(pk), 1);
    chk(reads == r0 + 2, "R11 no extra read", 32'(reads - r0), 2);

    // hit on the cached page
    va = mkva(2, 7, 12'hfe0);
    do_req(va, 0, code, pa, nrd, lat, rb, pk);
    ex = expect_xl(va, tbl_len);
    chk(code == 2'd0 && pa == ex[31:0], "R5 hit pa", pa, ex[31:0]);
    chk(nrd == 0, "R5 hit reads", 32'(nrd), 0);
    chk(lat == 1, "R5 hit latency", 32'(lat), 1);

    // outer fault, twice
    for (int k = 0; k < 2; k++) begin
      do_req(mkva(5, 1, 4), 0, code, pa, nrd, lat, rb, pk);
      chk(code == 2'd2 && pa == 0, "R4 outer fault", {code, pa[29:0]}, {2'd2, 30'd0});
      chk(nrd == 1, "R6 outer fault reads", 32'(nrd), 1);
    end
    // inner fault, twice
    for (int k = 0; k < 2; k++) begin
      do_req(mkva(3, 14, 8), 0, code, pa, nrd, lat, rb, pk);
      chk(code == 2'd3 && pa == 0, "R4 inner fault", {code, pa[29:0]}, {2'd3, 30'd0});
      chk(nrd == 2, "R6 inner fault reads", 32'(nrd), 2);
    end

    // length limit
    do_req(mkva(16, 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(code == 2'd1 && nrd == 0 && lat == 1, "R3 at limit", {code, 30'(nrd)}, {2'd1, 30'd0});
    do_req(mkva(15, 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(code == 2'd0 && nrd == 2, "R3 below limit", {code, 30'(nrd)}, {2'd0, 30'd2});
    tbl_len = 11'd2;
    do_req(mkva(2, 7, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(code == 2'd1 && nrd == 0, "R3 cached page past limit", {code, 30'(nrd)}, {2'd1, 30'd0});
    tbl_len = 11'd0;
    do_req(mkva(0, 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(code == 2'd1, "R3 zero length", 32'(code), 1);
    tbl_len = 11'd16;

    // flush
    do_req(mkva(2, 7, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 0, "R5 still cached", 32'(nrd), 0);
    tb_flush = 1'b1;
    @(negedge clk);
    tb_flush = 1'b0;
    do_req(mkva(2, 7, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 2, "R8 flush empties", 32'(nrd), 2);
    do_req(mkva(2, 7, 0), 1, code, pa, nrd, lat, rb, pk);
    ex = expect_xl(mkva(2, 7, 0), tbl_len);
    chk(nrd == 2 && pa == ex[31:0], "R8 flush with lookup", 32'(nrd), 2);
    flush_at_inner = 1;
    do_req(mkva(4, 9, 12'h55), 0, code, pa, nrd, lat, rb, pk);
    flush_at_inner = 0;
    ex = expect_xl(mkva(4, 9, 12'h55), tbl_len);
    chk(pa == ex[31:0] && code == 2'd0, "R8 flush at install result", pa, ex[31:0]);
    do_req(mkva(4, 9, 12'h55), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 2, "R8 install dropped", 32'(nrd), 2);

    // slow memory
    mem_stall = 3;
    do_req(mkva(6, 20, 12'h7), 0, code, pa, nrd, lat, rb, pk);
    ex = expect_xl(mkva(6, 20, 12'h7), tbl_len);
    chk(pa == ex[31:0], "R9 stalled pa", pa, ex[31:0]);
    chk(lat == 11, "R9 stalled latency", 32'(lat), 11);
    chk(rb == 0, "R9 ready low while stalled", 32'(rb), 0);
    mem_stall = 0;

    // replacement order over 33 distinct pages
    tbl_len = 11'd64;
    tb_flush = 1'b1;
    @(negedge clk);
    tb_flush = 1'b0;
    n = 0;
    for (int i = 0; n < 33; i++) if (i % 7 != 5) begin pg[n] = i; n++; end
    for (int k = 0; k < 33; k++) begin
      do_req(mkva(pg[k], 0, k), 0, code, pa, nrd, lat, rb, pk);
      chk(nrd == 2 && code == 2'd0, "R7 fill miss", 32'(nrd), 2);
    end
    do_req(mkva(pg[1], 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 0, "R7 second page kept", 32'(nrd), 0);
    do_req(mkva(pg[32], 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 0, "R7 newest page held", 32'(nrd), 0);
    do_req(mkva(pg[0], 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 2, "R7 first page evicted", 32'(nrd), 2);
    do_req(mkva(pg[2], 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 0, "R7 third page kept", 32'(nrd), 0);
    do_req(mkva(pg[1], 0, 0), 0, code, pa, nrd, lat, rb, pk);
    chk(nrd == 2, "R7 pointer advanced", 32'(nrd), 2);

    // sweep, twice so the second pass mostly hits
    tbl_len = 11'd20;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 22; i++) begin
        foreach (pg[q]) if (q < 7) begin
          int j;
          case (q)
            0: j = 0; 1: j = 1; 2: j = 3; 3: j = 11;
            4: j = 14; 5: j = 500; default: j = 1023;
          endcase
          va = mkva(i, j, (i * j * 13 + pass) & 12'hfff);
          ex = expect_xl(va, tbl_len);
          do_req(va, 0, code, pa, nrd, lat, rb, pk);
          chk(code == ex[33:32] && pa == ex[31:0], "R1 sweep", pa, ex[31:0]);
          case (ex[33:32])
            2'd0: chk(nrd == 0 || nrd == 2, "R5 sweep reads", 32'(nrd), 2);
            2'd1: chk(nrd == 0, "R3 sweep reads", 32'(nrd), 0);
            2'd2: chk(nrd == 1, "R4 sweep reads", 32'(nrd), 1);
            default: chk(nrd == 2, "R6 sweep reads", 32'(nrd), 2);
          endcase
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule